// File: doc/BRIEF.md
# Selectable-Edge Trigger Input Qualifier

This block sits between one external trigger pin and a timer's capture, clear-and-start and external one-shot logic. It synchronises the pin into the system clock domain. A level change counts only once it has held on several consecutive count-clock ticks. Each qualified change whose direction matches the selected edge produces a strobe that lasts one system clock cycle.

The timer-run enable gates the whole detector. While the timer is stopped the pin is ignored, and the last qualified level is kept so that a later re-enable compares the pin against it. The edge-select field can be written only while the timer is stopped. A cold-start flag, asserted by the surrounding logic for the first enable after reset, forces the reference level low on that enable. A pin that is already high then yields a rising strobe.

Top module: `trig_edge_qual`

## Requirements
- R1: A write to the edge-select field takes effect only when `run_en` is low in the write cycle. Writes made while running are ignored. The field is visible on `edge_sel`.
- R2: Edge-select encoding: 2'b00 reports falling edges only, 2'b01 reports rising edges only, 2'b11 reports both.
- R3: With edge-select 2'b10 no strobe is ever produced.
- R4: While `run_en` is low, pin activity produces no strobe.
- R5: A new pin level is accepted only after it has been seen on STABLE_TICKS (default 3) consecutive `cnt_tick` cycles. Pulses covering two ticks or fewer are rejected.
- R6: The last qualified level is held across a stop. A pin still high at a re-enable without `cold_start` produces no rising strobe.
- R7: On an enable with `cold_start` high, the reference level is forced low. A pin held high then produces one rising strobe when rising or both edges are selected.
- R8: Each strobe on `edge_stb` lasts exactly one system clock cycle.
- R9: During and after reset `edge_stb` is 0 and `edge_sel` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Timer running; low means stopped |
| cold_start | input | 1 | Marks the first enable after reset |
| cnt_tick | input | 1 | One-cycle count-clock enable used for qualification |
| sel_wr | input | 1 | Edge-select write strobe |
| sel_wdata | input | 2 | Edge-select write value |
| pin_in | input | 1 | Asynchronous trigger pin |
| edge_sel | output | 2 | Current edge-select field |
| edge_stb | output | 1 | Valid-edge strobe, one cycle wide |

## Verification
The pin is driven with long steady levels in each edge-select setting. Counting strobes per window separates rising-only, falling-only, both-edge and reserved behaviour. Short pulses spanning one and two ticks are set against long ones to locate the qualification threshold. Toggles while stopped, re-enables with the pin high with and without the cold-start flag, and writes attempted while running show apart the gating, the held reference level and the write lock.

// File: rtl/trig_edge_pkg.sv
// Package: shared edge-select encoding for the trigger qualifier.
// Assumes a 2-bit field; the value 2'b10 is reserved and means "no edges".
package trig_edge_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/trig_sync2.sv
// Module: two-flop synchroniser bringing the asynchronous pin into clk.
// Assumes the pin is a slow level signal; the output resets low.
module trig_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic stable_q;

    // Purpose: shift the pin through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/trig_level_qual.sv
// Module: level qualifier. It accepts a new synchronised level once it has
// differed from the held level on STABLE_TICKS consecutive count ticks.
// Assumes cnt_tick is a one-cycle enable. The held level survives a stop.
// A cold-start enable forces the held level low.
module trig_level_qual #(
    parameter int STABLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic cold_start,
    input  logic cnt_tick,
    input  logic sync_lvl,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(STABLE_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          run_d_q;
    logic          mism;
    logic          cold_arm;
    logic          accept;

    // Purpose: decode the mismatch, the cold enable and the acceptance point.
    always_comb begin
        mism     = (sync_lvl != lvl_q);
        cold_arm = run_en && !run_d_q && cold_start;
        accept   = run_en && !cold_arm && cnt_tick && mism && (cnt_q == LAST_CNT);
        rise_now = accept && sync_lvl;
        fall_now = accept && !sync_lvl;
    end

    // Purpose: count stable ticks and update the held level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            run_d_q <= 1'b0;
        end else begin
            run_d_q <= run_en;
            if (!run_en) begin
                cnt_q <= '0;
            end else if (cold_arm) begin
                lvl_q <= 1'b0;
                cnt_q <= '0;
            end else if (!mism) begin
                cnt_q <= '0;
            end else if (cnt_tick) begin
                if (accept) begin
                    lvl_q <= sync_lvl;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_LVL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !(cold_start && run_en)) |=> $stable(lvl_q)); // R5
    AST_LVL_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(lvl_q)); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(STABLE_TICKS)); // R5
endmodule

// File: rtl/trig_edge_decode.sv
// Module: compares a qualified transition with the selected edge and
// registers a one-cycle strobe. Assumes rise_now and fall_now never
// occur together.
module trig_edge_decode
    import trig_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise_now,
    input  logic      fall_now,
    input  edge_sel_e sel,
    output logic      stb
);
    logic hit;

    // Purpose: match the transition direction against the selection.
    always_comb begin
        unique case (sel)
            EDGE_FALL: hit = fall_now;
            EDGE_RISE: hit = rise_now;
            EDGE_BOTH: hit = rise_now || fall_now;
            default:   hit = 1'b0;
        endcase
    end

    // Purpose: register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) stb <= 1'b0;
        else        stb <= hit;
    end

    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |=> !stb); // R3
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R8
    AST_SINGLE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_now && fall_now)); // R2
endmodule

// File: rtl/trig_edge_qual.sv
// Module: top of the trigger qualifier. It holds the edge-select field,
// which can be written only while stopped, and chains the synchroniser,
// the level qualifier and the edge decoder. Assumes run_en is low for a
// stopped timer.
module trig_edge_qual
    import trig_edge_pkg::*;
#(
    parameter int STABLE_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       cold_start,
    input  logic       cnt_tick,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       pin_in,
    output logic [1:0] edge_sel,
    output logic       edge_stb
);
    edge_sel_e sel_q;
    logic      sync_lvl;
    logic      rise_now;
    logic      fall_now;

    // Purpose: accept edge-select writes only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                sel_q <= EDGE_FALL;
        else if (sel_wr && !run_en) sel_q <= edge_sel_e'(sel_wdata);
    end

    assign edge_sel = sel_q;

    trig_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    trig_level_qual #(.STABLE_TICKS(STABLE_TICKS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .cold_start (cold_start),
        .cnt_tick   (cnt_tick),
        .sync_lvl   (sync_lvl),
        .rise_now   (rise_now),
        .fall_now   (fall_now)
    );

    trig_edge_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .sel      (sel_q),
        .stb      (edge_stb)
    );

    AST_SEL_LOCKED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(sel_q)); // R1
    AST_NO_STB_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !edge_stb); // R4
endmodule

// File: tb/trig_edge_qual_bench.sv
module trig_edge_qual_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       cold_start = 1'b0;
    logic       cnt_tick = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       pin_in = 1'b0;
    logic [1:0] edge_sel;
    logic       edge_stb;

    int n_checks = 0;
    int n_fail = 0;
    int obs_cnt = 0;
    bit done = 1'b0;
    bit chk_pending = 1'b0;
    bit prev_stb = 1'b0;
    logic [1:0] div_q = 2'b00;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    trig_edge_qual u_trig_edge_qual (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cold_start(cold_start),
        .cnt_tick(cnt_tick), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .pin_in(pin_in), .edge_sel(edge_sel), .edge_stb(edge_stb)
    );

    // count clock: one tick every four system cycles
    always @(posedge clk) begin
        div_q    <= div_q + 2'd1;
        cnt_tick <= (div_q == 2'd3);
    end

    // monitor: count strobes, check width, pop and compare expected counts
    always @(negedge clk) begin
        if (rst_n) begin
            if (edge_stb && prev_stb) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8: strobe high two cycles, actual 2 expected 1");
            end
            prev_stb = edge_stb;
            if (edge_stb) obs_cnt++;
        end
        if (chk_pending) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (obs_cnt != e) begin
                n_fail++;
                $display("FAIL %s: strobe count actual %0d expected %0d", t, obs_cnt, e);
            end
            obs_cnt = 0;
            chk_pending = 1'b0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver side of the scoreboard: push the expected count, then hand off
    task automatic expect_strobes(input int n, input string tag);
        exp_q.push_back(n);
        tag_q.push_back(tag);
        chk_pending = 1'b1;
        while (chk_pending) @(posedge clk);
        #1;
    endtask

    task automatic check_val(input logic [1:0] act, input logic [1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        cyc(1);
        sel_wr = 1'b0;
        cyc(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        pin_in = 1'b1;
        cyc(5);
        check_val({1'b0, edge_stb}, 2'b00, "R9 reset strobe");
        check_val(edge_sel, 2'b00, "R9 reset select");
        rst_n = 1'b1;
        cyc(10);
        expect_strobes(0, "R4 pin high while stopped");
        // R1: write while stopped accepted
        write_sel(2'b01);
        check_val(edge_sel, 2'b01, "R1 write while stopped");
        // R7: cold first enable with pin high -> rising strobe
        cold_start = 1'b1; run_en = 1'b1;
        cyc(2); cold_start = 1'b0;
        cyc(40);
        expect_strobes(1, "R7 cold enable pin high");
        // R2 rising only: fall ignored, rise reported
        pin_in = 1'b0; cyc(40);
        expect_strobes(0, "R2 rising-only ignores fall");
        pin_in = 1'b1; cyc(40);
        expect_strobes(1, "R2 rising-only reports rise");
        // R1: write while running ignored
        write_sel(2'b11);
        check_val(edge_sel, 2'b01, "R1 write while running");
        pin_in = 1'b0; cyc(40);
        expect_strobes(0, "R1 ignored write keeps rising-only");
        // R5: one-tick and two-tick pulses rejected, long accepted
        pin_in = 1'b1; cyc(3); pin_in = 1'b0; cyc(40);
        expect_strobes(0, "R5 one-tick glitch");
        pin_in = 1'b1; cyc(8); pin_in = 1'b0; cyc(40);
        expect_strobes(0, "R5 two-tick pulse");
        pin_in = 1'b1; cyc(40);
        expect_strobes(1, "R5 long pulse accepted");
        // R4: stopped, toggles ignored; R6 re-enable with pin high
        run_en = 1'b0; cyc(2);
        pin_in = 1'b0; cyc(40); pin_in = 1'b1; cyc(40);
        expect_strobes(0, "R4 toggles while stopped");
        write_sel(2'b11);
        check_val(edge_sel, 2'b11, "R1 both selected while stopped");
        run_en = 1'b1; cyc(40);
        expect_strobes(0, "R6 re-enable pin high no edge");
        // R2 both edges
        pin_in = 1'b0; cyc(40);
        expect_strobes(1, "R2 both reports fall");
        pin_in = 1'b1; cyc(40);
        expect_strobes(1, "R2 both reports rise");
        // R3 reserved
        run_en = 1'b0; cyc(2);
        write_sel(2'b10);
        run_en = 1'b1; cyc(2);
        pin_in = 1'b0; cyc(40); pin_in = 1'b1; cyc(40);
        expect_strobes(0, "R3 reserved silent");
        // R2 falling only
        run_en = 1'b0; cyc(2);
        write_sel(2'b00);
        run_en = 1'b1; cyc(2);
        pin_in = 1'b0; cyc(40);
        expect_strobes(1, "R2 falling-only reports fall");
        pin_in = 1'b1; cyc(40);
        expect_strobes(0, "R2 falling-only ignores rise");
        // R7 cold flag on a later enable forces reference low
        run_en = 1'b0; cyc(2);
        write_sel(2'b01);
        cold_start = 1'b1; run_en = 1'b1;
        cyc(2); cold_start = 1'b0;
        cyc(40);
        expect_strobes(1, "R7 cold flag forces rise");
        finish_run();
    end
endmodule